// File: doc/BRIEF.md
# Board Control and Parity Error Capture

This block holds the host-visible control and status word of a network interface board. It also holds the registers that record a memory parity failure. The host writes the control word to do several things: hold the network controller in reset, take the interface out of loopback, request attention from the controller, enable the two interrupt sources, enable the expansion bus, pick the memory device size and set four high address bits. Reading the same word returns those settings together with the live controller interrupt request and the parity error flag.

On a memory parity error, the block records the following: the low sixteen bits of the failing address, address bits 20 down to 17, the bus master that made the access, and the byte lane that failed. These fields stay frozen until the host writes an acknowledge. The acknowledge also clears the flag. The block combines both interrupt causes into a single request line, and that line is forced low while the controller is held in reset.

Top module: `board_ctl`

## Requirements
- R1: After rst_ni is released, the status word (address 0) reads 0x8000, ctl_reset_o is 1, irq_o, atten_o, on_air_o, exp_bus_en_o and big_ram_o are 0, hi_addr_o is 0, and addresses 1 and 2 read 0.
- R2: A write to address 0 stores the following bits, and they read back from the next cycle: bit 15 (ctl_reset_o), bit 14 (on_air_o), bit 13 (attention level), bit 12 (controller interrupt enable), bit 11 (parity interrupt enable), bit 5 (exp_bus_en_o), bit 4 (big_ram_o) and bits 3:0 (hi_addr_o). Bits 10, 7 and 6 read 0, and written values of bits 9 and 8 are ignored.
- R3: atten_o is high for exactly the one cycle after a status write whose bit 13 differs from the stored bit 13. A status write that leaves bit 13 unchanged produces no pulse.
- R4: Status bit 8 reads the current level of ctrl_irq_i, and status bit 9 reads the parity error flag.
- R5: When par_err_i is high and the flag is clear, the flag is set and the error is recorded, visible from the next cycle. Address 2 reads par_addr_i[15:0]. Address 1 reads par_addr_i[20:17] in bits 3:0, par_src_i in bit 7 and par_lane_i in bit 6. All other bits read 0.
- R6: While the flag is set and no acknowledge is written, further par_err_i pulses change neither the flag nor the recorded fields.
- R7: A write to address 1 with bit 8 set clears the flag. The recorded fields keep their values, and bit 8 always reads 0. A write to address 1 with bit 8 clear has no effect.
- R8: If an acknowledge write and par_err_i fall on the same edge, the new error is recorded and the flag stays set.
- R9: irq_o = (ctrl_irq_i AND status bit 12) OR (parity flag AND status bit 11).
- R10: irq_o is 0 whenever status bit 15 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 status, 1 parity control, 2 parity low address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| ctrl_irq_i | input | 1 | Interrupt request from the network controller |
| par_err_i | input | 1 | Parity error strobe from the memory |
| par_addr_i | input | 21 | Address of the failing access |
| par_src_i | input | 1 | Bus master of the failing access |
| par_lane_i | input | 1 | Byte lane that failed |
| ctl_reset_o | output | 1 | Holds the controller in reset |
| on_air_o | output | 1 | Leaves loopback, connects to the network |
| atten_o | output | 1 | Single-cycle attention pulse to the controller |
| exp_bus_en_o | output | 1 | Expansion bus enable |
| big_ram_o | output | 1 | Larger memory device size select |
| hi_addr_o | output | 4 | High address bits 20:17 |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an acknowledge write and a fresh parity error landing on the same clock edge. Here the capture has to win over the clear. The bench drives the register write and the parity strobe in the same half cycle and then reads both the flag and the new fields. The freeze path needs a second error while the first one is still pending. The bench therefore keeps the flag set through a deliberate no-op write (bit 8 clear) before it acknowledges.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;
  localparam int DW    = 16;
  localparam int LO_W  = 16;
  localparam int HI_W  = 4;
  localparam int HI_LSB = LO_W + 1;

  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_PARCTL = 2'd1;
  localparam logic [1:0] SEL_PARADR = 2'd2;

  // status word bit positions
  localparam int S_RST   = 15;
  localparam int S_AIR   = 14;
  localparam int S_ATTN  = 13;
  localparam int S_IE    = 12;
  localparam int S_PIE   = 11;
  localparam int S_PFLAG = 9;
  localparam int S_CIRQ  = 8;
  localparam int S_EXP   = 5;
  localparam int S_BIG   = 4;

  // parity control bit positions
  localparam int P_ACK  = 8;
  localparam int P_SRC  = 7;
  localparam int P_LANE = 6;

  typedef struct packed {
    logic            rst;
    logic            air;
    logic            attn;
    logic            ie;
    logic            pie;
    logic            exp;
    logic            big;
    logic [HI_W-1:0] hi;
  } stat_t;

  typedef struct packed {
    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] lo;
    logic            src;
    logic            lane;
  } perr_rec_t;
endpackage

// File: rtl/bc_status_reg.sv
module bc_status_reg
  import board_ctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output stat_t         stat_o,
  output logic          atten_o
);
  stat_t stat_q;
  logic  atten_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q     <= '0;
      stat_q.rst <= 1'b1;
      atten_q    <= 1'b0;
    end else begin
      atten_q <= wr_i && (wdata_i[S_ATTN] != stat_q.attn);
      if (wr_i) begin
        stat_q.rst  <= wdata_i[S_RST];
        stat_q.air  <= wdata_i[S_AIR];
        stat_q.attn <= wdata_i[S_ATTN];
        stat_q.ie   <= wdata_i[S_IE];
        stat_q.pie  <= wdata_i[S_PIE];
        stat_q.exp  <= wdata_i[S_EXP];
        stat_q.big  <= wdata_i[S_BIG];
        stat_q.hi   <= wdata_i[HI_W-1:0];
      end
    end
  end

  assign stat_o  = stat_q;
  assign atten_o = atten_q;
endmodule

// File: rtl/bc_parity_capture.sv
module bc_parity_capture
  import board_ctl_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic              err_src_i,
  input  logic              err_lane_i,
  input  logic              ack_i,
  output logic              flag_o,
  output perr_rec_t         rec_o
);
  localparam int HI_MSB = HI_LSB + HI_W - 1;

  logic      flag_q;
  perr_rec_t rec_q;
  logic      take;

  // an acknowledge on the same edge reopens the capture window
  assign take = err_i && (!flag_q || ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      rec_q  <= '0;
    end else if (take) begin
      flag_q     <= 1'b1;
      rec_q.hi   <= err_addr_i[HI_MSB:HI_LSB];
      rec_q.lo   <= err_addr_i[LO_W-1:0];
      rec_q.src  <= err_src_i;
      rec_q.lane <= err_lane_i;
    end else if (ack_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign rec_o  = rec_q;
endmodule

// File: rtl/bc_irq_gen.sv
module bc_irq_gen
  import board_ctl_pkg::*;
(
  input  stat_t stat_i,
  input  logic  ctrl_irq_i,
  input  logic  flag_i,
  output logic  irq_o
);
  logic ctrl_req, par_req;

  assign ctrl_req = ctrl_irq_i & stat_i.ie;
  assign par_req  = flag_i & stat_i.pie;
  assign irq_o    = ~stat_i.rst & (ctrl_req | par_req);
endmodule

// File: rtl/bc_read_mux.sv
module bc_read_mux
  import board_ctl_pkg::*;
(
  input  logic [1:0]    sel_i,
  input  stat_t         stat_i,
  input  logic          ctrl_irq_i,
  input  logic          flag_i,
  input  perr_rec_t     rec_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] stat_word, pctl_word;

  always_comb begin
    stat_word              = '0;
    stat_word[S_RST]       = stat_i.rst;
    stat_word[S_AIR]       = stat_i.air;
    stat_word[S_ATTN]      = stat_i.attn;
    stat_word[S_IE]        = stat_i.ie;
    stat_word[S_PIE]       = stat_i.pie;
    stat_word[S_PFLAG]     = flag_i;
    stat_word[S_CIRQ]      = ctrl_irq_i;
    stat_word[S_EXP]       = stat_i.exp;
    stat_word[S_BIG]       = stat_i.big;
    stat_word[HI_W-1:0]    = stat_i.hi;

    pctl_word              = '0;
    pctl_word[P_SRC]       = rec_i.src;
    pctl_word[P_LANE]      = rec_i.lane;
    pctl_word[HI_W-1:0]    = rec_i.hi;

    unique case (sel_i)
      SEL_STATUS: rdata_o = stat_word;
      SEL_PARCTL: rdata_o = pctl_word;
      SEL_PARADR: rdata_o = rec_i.lo;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/board_ctl.sv
module board_ctl
  import board_ctl_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              ctrl_irq_i,
  input  logic              par_err_i,
  input  logic [ADDR_W-1:0] par_addr_i,
  input  logic              par_src_i,
  input  logic              par_lane_i,
  output logic              ctl_reset_o,
  output logic              on_air_o,
  output logic              atten_o,
  output logic              exp_bus_en_o,
  output logic              big_ram_o,
  output logic [HI_W-1:0]   hi_addr_o,
  output logic              irq_o
);
  stat_t     stat;
  perr_rec_t par_rec;
  logic      par_flag;
  logic      stat_wr, ack_wr;

  assign stat_wr = wr_en_i && (addr_i == SEL_STATUS);
  assign ack_wr  = wr_en_i && (addr_i == SEL_PARCTL) && wdata_i[P_ACK];

  bc_status_reg u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (stat_wr),
    .wdata_i (wdata_i),
    .stat_o  (stat),
    .atten_o (atten_o)
  );

  bc_parity_capture #(.ADDR_W(ADDR_W)) u_par (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .err_i      (par_err_i),
    .err_addr_i (par_addr_i),
    .err_src_i  (par_src_i),
    .err_lane_i (par_lane_i),
    .ack_i      (ack_wr),
    .flag_o     (par_flag),
    .rec_o      (par_rec)
  );

  bc_irq_gen u_irq (
    .stat_i     (stat),
    .ctrl_irq_i (ctrl_irq_i),
    .flag_i     (par_flag),
    .irq_o      (irq_o)
  );

  bc_read_mux u_rd (
    .sel_i      (addr_i),
    .stat_i     (stat),
    .ctrl_irq_i (ctrl_irq_i),
    .flag_i     (par_flag),
    .rec_i      (par_rec),
    .rdata_o    (rdata_o)
  );

  assign ctl_reset_o  = stat.rst;
  assign on_air_o     = stat.air;
  assign exp_bus_en_o = stat.exp;
  assign big_ram_o    = stat.big;
  assign hi_addr_o    = stat.hi;
endmodule

// File: rtl/board_ctl_chk.sv
module board_ctl_chk
  import board_ctl_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  addr_i,
  input logic [15:0] wdata_i,
  input logic        par_err_i,
  input logic [20:0] par_addr_i,
  input logic        ctl_reset_o,
  input logic        on_air_o,
  input logic        atten_o,
  input logic        irq_o,
  input logic        flag_i,
  input perr_rec_t   rec_i
);
  logic ack_w;
  assign ack_w = wr_en_i && (addr_i == 2'd1) && wdata_i[8];

  p_air_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0) |=> (on_air_o == $past(wdata_i[14])));

  p_atten_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atten_o |-> $past(wr_en_i && addr_i == 2'd0));

  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_i && !flag_i) |=> (flag_i && rec_i.lo == $past(par_addr_i[15:0])));

  p_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !ack_w) |=> (flag_i && $stable(rec_i)));

  p_ack_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_w && !par_err_i) |=> !flag_i);

  p_ack_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_w && par_err_i) |=> flag_i);

  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_reset_o |-> !irq_o);
endmodule

bind board_ctl board_ctl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .par_err_i  (par_err_i),
  .par_addr_i (par_addr_i),
  .ctl_reset_o(ctl_reset_o),
  .on_air_o   (on_air_o),
  .atten_o    (atten_o),
  .irq_o      (irq_o),
  .flag_i     (par_flag),
  .rec_i      (par_rec)
);

// File: tb/tb_board_ctl.sv
`timescale 1ns/1ps
module tb_board_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ctrl_irq = 1'b0;
  logic        par_err = 1'b0;
  logic [20:0] par_addr = '0;
  logic        par_src = 1'b0;
  logic        par_lane = 1'b0;
  logic        ctl_reset, on_air, atten, exp_en, big_ram, irq;
  logic [3:0]  hi_addr;

  int checks = 0;
  int fails  = 0;
  logic atten_seen;

  always #2.5 clk = ~clk;

  board_ctl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ctrl_irq_i(ctrl_irq),
    .par_err_i(par_err), .par_addr_i(par_addr), .par_src_i(par_src),
    .par_lane_i(par_lane), .ctl_reset_o(ctl_reset), .on_air_o(on_air),
    .atten_o(atten), .exp_bus_en_o(exp_en), .big_ram_o(big_ram),
    .hi_addr_o(hi_addr), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    atten_seen = atten;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic perr(input logic [20:0] a, input logic s, input logic l);
    @(negedge clk);
    par_err = 1'b1; par_addr = a; par_src = s; par_lane = l;
    @(negedge clk);
    par_err = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(2'd0, d); chk("R1 status", d, 16'h8000);
    rd(2'd1, d); chk("R1 parctl", d, 16'h0000);
    rd(2'd2, d); chk("R1 paradr", d, 16'h0000);
    chk("R1 outputs", {9'd0, ctl_reset, on_air, atten, exp_en, big_ram, irq, hi_addr == 4'd0},
        16'h0041);
  endtask

  task automatic t_status;
    logic [15:0] d;
    wr(2'd0, 16'h7F3A);
    rd(2'd0, d); chk("R2 readback", d, 16'h783A);
    chk("R2 pins", {11'd0, ctl_reset, on_air, exp_en, big_ram, 1'b0} | {12'd0, hi_addr},
        {11'd0, 5'b01110} | 16'h000A);
    chk("R3 pulse on change", {15'd0, atten_seen}, 16'h0001);
    @(negedge clk);
    chk("R3 one cycle", {15'd0, atten}, 16'h0000);
    wr(2'd0, 16'h2000);
    chk("R3 no pulse unchanged", {15'd0, atten_seen}, 16'h0000);
    wr(2'd0, 16'h0000);
    chk("R3 pulse on clear", {15'd0, atten_seen}, 16'h0001);
  endtask

  task automatic t_irq_bit;
    logic [15:0] d;
    ctrl_irq = 1'b1;
    rd(2'd0, d); chk("R4 ctrl irq bit", d, 16'h0100);
    ctrl_irq = 1'b0;
    rd(2'd0, d); chk("R4 ctrl irq low", d, 16'h0000);
  endtask

  task automatic t_capture;
    logic [15:0] d;
    perr({4'hB, 1'b1, 16'h1234}, 1'b1, 1'b0);
    rd(2'd1, d); chk("R5 parctl", d, 16'h008B);
    rd(2'd2, d); chk("R5 paradr", d, 16'h1234);
    rd(2'd0, d); chk("R4 flag bit", d, 16'h0200);
    perr({4'h3, 1'b0, 16'h5678}, 1'b0, 1'b1);
    rd(2'd1, d); chk("R6 frozen parctl", d, 16'h008B);
    rd(2'd2, d); chk("R6 frozen paradr", d, 16'h1234);
    wr(2'd1, 16'h00FF);
    rd(2'd0, d); chk("R7 no ack keeps flag", d, 16'h0200);
    rd(2'd1, d); chk("R7 no ack fields", d, 16'h008B);
    wr(2'd1, 16'h0100);
    rd(2'd0, d); chk("R7 ack clears flag", d, 16'h0000);
    rd(2'd1, d); chk("R7 fields kept ack reads 0", d, 16'h008B);
    perr({4'h3, 1'b0, 16'h5678}, 1'b0, 1'b1);
    rd(2'd1, d); chk("R5 recapture parctl", d, 16'h0043);
    rd(2'd2, d); chk("R5 recapture paradr", d, 16'h5678);
  endtask

  task automatic t_ack_err;
    logic [15:0] d;
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 16'h0100;
    par_err = 1'b1; par_addr = {4'h7, 1'b0, 16'h9ABC}; par_src = 1'b1; par_lane = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; par_err = 1'b0;
    rd(2'd0, d); chk("R8 flag kept", d, 16'h0200);
    rd(2'd1, d); chk("R8 new parctl", d, 16'h00C7);
    rd(2'd2, d); chk("R8 new paradr", d, 16'h9ABC);
  endtask

  task automatic t_irq;
    wr(2'd0, 16'h0800);
    #0.5 chk("R9 parity irq", {15'd0, irq}, 16'h0001);
    wr(2'd0, 16'h1000);
    #0.5 chk("R9 ctrl enable no req", {15'd0, irq}, 16'h0000);
    ctrl_irq = 1'b1;
    #0.5 chk("R9 ctrl irq", {15'd0, irq}, 16'h0001);
    wr(2'd0, 16'h9800);
    #0.5 chk("R10 held low in reset", {15'd0, irq}, 16'h0000);
    ctrl_irq = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #10000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_irq_bit();
    t_capture();
    t_ack_err();
    t_irq();
    summary();
  end
endmodule